// File: doc/BRIEF.md
# Byte-Lane Write Control with Flow-Through Word Store

This block sits behind a synchronous 32-bit memory port. On every rising clock edge it decides which of four byte lanes will be written. Three controls feed that decision: a global write enable, a byte-write enable and four per-lane selects. A processor address strobe can also veto a byte write. The block registers the resulting lane mask, the write data and the address, and commits them into a small word store on the next active edge.

Read data is not registered. The word at the registered address drives the read bus directly, so a read appears in the same cycle the address is captured. The read drivers are switched off while a write is pending. They are also off while the output enable is high or the block is deselected.

A sleep input freezes every register and the store contents for as long as it is high. When the input falls, operation resumes where it stopped.

Top module: `bw_ctrl_top`

## Requirements
- R1: When `gw_n` is low at an active edge, `wr_lanes` becomes 4'b1111 after that edge. This holds whatever `bwe_n`, `bsel_n` and `adsp_n` are.
- R2: When `gw_n` is high, `bwe_n` is low and `adsp_n` is high at an active edge, `wr_lanes[i]` becomes the inverse of `bsel_n[i]` after that edge.
- R3: When `gw_n` and `bwe_n` are both high at an active edge, `wr_lanes` becomes 4'b0000.
- R4: When `gw_n` is high and `adsp_n` is low at an active edge, `wr_lanes` becomes 4'b0000 whatever `bsel_n` is.
- R5: Lane i covers data bits 8i+7:8i, so lane 0 is bits 7:0 and lane 3 is bits 31:24. A commit writes only the lanes set in `wr_lanes`. Every other lane of that word keeps its previous contents.
- R6: `wdata` and `addr` are captured at the edge that sets `wr_lanes`. The captured data is committed to the captured address at the next active edge.
- R7: `rdata` always shows the stored word at the most recently captured address, with no extra register stage.
- R8: `rd_drive` is high only when `oe_n` is low, `sel` was high at the last active edge and `wr_lanes` is zero. `oe_n` acts combinationally.
- R9: While `sleep` is high at an edge, no register and no stored word changes. A pending commit waits for the first edge with `sleep` low.
- R10: After reset, `wr_lanes` is zero, `rd_drive` is low, the captured address is zero and every stored word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep | input | 1 | High freezes all state |
| sel | input | 1 | Device select, registered |
| oe_n | input | 1 | Active-low read output enable, combinational |
| gw_n | input | 1 | Active-low global write, all lanes |
| bwe_n | input | 1 | Active-low gate for the per-lane selects |
| adsp_n | input | 1 | Active-low processor address strobe; vetoes byte writes |
| bsel_n | input | 4 | Active-low per-lane write selects |
| addr | input | 4 | Word address, registered |
| wdata | input | 32 | Write data, registered |
| wr_lanes | output | 4 | Registered lane mask of the pending write |
| rdata | output | 32 | Flow-through read word at the registered address |
| rd_drive | output | 1 | Read bus drive enable |

## Verification
Suppose the lane decoder were wrong, for example with the veto or the override inverted. `wr_lanes` would then be wrong immediately after the edge concerned. The bench sweeps every combination of the write controls and the lane selects, so such a fault shows on the first combination it affects. A wrong lane mapping or a misplaced commit stage shows one cycle later. It appears as a wrong byte of `rdata` at the next read of that address, and a bench model of the store catches it. A sleep gate that leaks shows as a changed mask or word across a frozen edge.

// File: rtl/bw_pkg.sv
// Shared constants and types for the byte-lane write control block.
// Assumes byte-wide lanes; only the lane count and store depth vary.
package bw_pkg;
    localparam int unsigned LANES_DEF  = 4;
    localparam int unsigned LANE_W_DEF = 8;
    localparam int unsigned ADDR_W_DEF = 4;

    // Which control started the write decided at an edge.
    typedef enum logic [1:0] {
        WSRC_NONE   = 2'd0,
        WSRC_GLOBAL = 2'd1,
        WSRC_BYTE   = 2'd2
    } wr_src_e;
endpackage

// File: rtl/bw_lane_decode.sv
// Combinational lane decision for one edge.
// The global write wins over everything. Per-lane selects count only while
// the byte gate is low and the processor strobe is high.
// Assumes all controls are active low.
module bw_lane_decode
    import bw_pkg::*;
#(
    parameter int unsigned LANES = LANES_DEF
) (
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic             adsp_n,
    input  logic [LANES-1:0] bsel_n,
    output logic [LANES-1:0] lane_mask,
    output wr_src_e          wr_src
);
    // Priority choice of write source.
    always_comb begin
        if (!gw_n)
            wr_src = WSRC_GLOBAL;
        else if (!bwe_n && adsp_n && (bsel_n != {LANES{1'b1}}))
            wr_src = WSRC_BYTE;
        else
            wr_src = WSRC_NONE;
    end

    // Expand the chosen source into a lane mask.
    always_comb begin
        unique case (wr_src)
            WSRC_GLOBAL: lane_mask = {LANES{1'b1}};
            WSRC_BYTE:   lane_mask = ~bsel_n;
            default:     lane_mask = '0;
        endcase
    end
endmodule

// File: rtl/bw_stage_reg.sv
// Input capture stage: address, write data, lane mask and select.
// All flops advance only on edges where the clock enable is high.
// Reset is synchronous and active low.
module bw_stage_reg #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic [ADDR_W-1:0] addr_d,
    input  logic [DATA_W-1:0] wdata_d,
    input  logic [LANES-1:0]  lane_d,
    input  logic              sel_d,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [LANES-1:0]  lane_q,
    output logic              sel_q
);
    // Capture the edge's inputs when awake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            lane_q  <= '0;
            sel_q   <= 1'b0;
        end else if (ce) begin
            addr_q  <= addr_d;
            wdata_q <= wdata_d;
            lane_q  <= lane_d;
            sel_q   <= sel_d;
        end
    end
endmodule

// File: rtl/bw_lane_store.sv
// One byte lane of the word store.
// It writes on an enabled edge at the given address and reads the same
// address combinationally. Assumes a small depth, so reset clears every
// entry.
module bw_lane_store #(
    parameter int unsigned LANE_W = 8,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANE_W-1:0] wbyte,
    output logic [LANE_W-1:0] rbyte
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] mem [DEPTH];

    // Clear on reset, otherwise write the lane when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
        end else if (we) begin
            mem[addr] <= wbyte;
        end
    end

    // Flow-through read.
    always_comb rbyte = mem[addr];
endmodule

// File: rtl/bw_ctrl_top.sv
// Byte-lane write control with a flow-through word store.
// It decodes the write controls, captures the mask, data and address, and
// commits them one active edge later. Reads are not registered.
// Assumes: sleep and all write controls are sampled on the rising edge;
// oe_n is combinational.
module bw_ctrl_top
    import bw_pkg::*;
#(
    parameter int unsigned LANES  = LANES_DEF,
    parameter int unsigned LANE_W = LANE_W_DEF,
    parameter int unsigned ADDR_W = ADDR_W_DEF
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sleep,
    input  logic                      sel,
    input  logic                      oe_n,
    input  logic                      gw_n,
    input  logic                      bwe_n,
    input  logic                      adsp_n,
    input  logic [LANES-1:0]          bsel_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [LANES*LANE_W-1:0]   wdata,
    output logic [LANES-1:0]          wr_lanes,
    output logic [LANES*LANE_W-1:0]   rdata,
    output logic                      rd_drive
);
    localparam int unsigned DATA_W = LANES * LANE_W;

    logic              awake;
    logic [LANES-1:0]  lane_d;
    wr_src_e           wr_src;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              sel_q;

    // Gate every state update while asleep.
    always_comb awake = !sleep;

    bw_lane_decode #(.LANES(LANES)) u_dec (
        .gw_n      (gw_n),
        .bwe_n     (bwe_n),
        .adsp_n    (adsp_n),
        .bsel_n    (bsel_n),
        .lane_mask (lane_d),
        .wr_src    (wr_src)
    );

    bw_stage_reg #(.LANES(LANES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce      (awake),
        .addr_d  (addr),
        .wdata_d (wdata),
        .lane_d  (lane_d),
        .sel_d   (sel),
        .addr_q  (addr_q),
        .wdata_q (wdata_q),
        .lane_q  (wr_lanes),
        .sel_q   (sel_q)
    );

    // One store per lane; the commit uses the address captured with the mask.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        bw_lane_store #(.LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_store (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (awake && wr_lanes[g]),
            .addr  (addr_q),
            .wbyte (wdata_q[g*LANE_W +: LANE_W]),
            .rbyte (rdata[g*LANE_W +: LANE_W])
        );
    end

    // Drive the read bus only when enabled, selected and no write is pending.
    always_comb rd_drive = !oe_n && sel_q && (wr_lanes == '0);
endmodule

// File: rtl/bw_ctrl_chk.sv
// Property checker for bw_ctrl_top, attached by bind below.
module bw_ctrl_chk #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sleep,
    input logic              gw_n,
    input logic              bwe_n,
    input logic              adsp_n,
    input logic [LANES-1:0]  bsel_n,
    input logic [LANES-1:0]  wr_lanes,
    input logic [DATA_W-1:0] rdata,
    input logic              rd_drive
);
    // R1
    gw_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !gw_n) |=> (wr_lanes == {LANES{1'b1}}));

    // R2
    byte_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && gw_n && !bwe_n && adsp_n) |=> (wr_lanes == ~$past(bsel_n)));

    // R3
    bwe_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && gw_n && bwe_n) |=> (wr_lanes == '0));

    // R4
    adsp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && gw_n && !adsp_n) |=> (wr_lanes == '0));

    // R8
    drive_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lanes != '0) |-> !rd_drive);

    // R9
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> ($stable(wr_lanes) && $stable(rdata)));
endmodule

bind bw_ctrl_top bw_ctrl_chk #(.LANES(LANES), .DATA_W(LANES*LANE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep    (sleep),
    .gw_n     (gw_n),
    .bwe_n    (bwe_n),
    .adsp_n   (adsp_n),
    .bsel_n   (bsel_n),
    .wr_lanes (wr_lanes),
    .rdata    (rdata),
    .rd_drive (rd_drive)
);

// File: tb/sim_bw_ctrl_top.sv
module sim_bw_ctrl_top;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sleep = 1'b0;
    logic        sel = 1'b0;
    logic        oe_n = 1'b1;
    logic        gw_n = 1'b1;
    logic        bwe_n = 1'b1;
    logic        adsp_n = 1'b1;
    logic [3:0]  bsel_n = 4'hF;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  wr_lanes;
    logic [31:0] rdata;
    logic        rd_drive;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // bench model
    logic [31:0] mem_m [16];
    logic [3:0]  pend_m = '0;
    logic [3:0]  addr_m = '0;
    logic [31:0] data_m = '0;
    logic        sel_m = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    bw_ctrl_top u0 (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .sel(sel), .oe_n(oe_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .adsp_n(adsp_n), .bsel_n(bsel_n),
        .addr(addr), .wdata(wdata), .wr_lanes(wr_lanes), .rdata(rdata),
        .rd_drive(rd_drive)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Lane mask derived from R1..R4.
    function automatic logic [3:0] exp_mask(input logic g, b, p, input logic [3:0] s);
        if (!g) return 4'hF;
        if (!b && p) return ~s;
        return 4'h0;
    endfunction

    task automatic step(input logic g, b, p, input logic [3:0] s, input logic [3:0] a,
                        input logic [31:0] d, input logic slp, o, cs,
                        input string ltag, input string dtag);
        @(negedge clk);
        gw_n = g; bwe_n = b; adsp_n = p; bsel_n = s; addr = a; wdata = d;
        sleep = slp; oe_n = o; sel = cs;
        @(posedge clk);
        #1;
        if (!slp) begin
            for (int i = 0; i < 4; i++)
                if (pend_m[i]) mem_m[addr_m][i*8 +: 8] = data_m[i*8 +: 8];
            pend_m = exp_mask(g, b, p, s);
            addr_m = a; data_m = d; sel_m = cs;
        end
        chk(ltag, {28'd0, wr_lanes}, {28'd0, pend_m});
        chk(dtag, rdata, mem_m[addr_m]);
        chk("R8", {31'd0, rd_drive}, {31'd0, (!o && sel_m && pend_m == 4'h0)});
    endtask

    initial begin
        for (int k = 0; k < 16; k++) mem_m[k] = '0;
        oe_n = 1'b0; sel = 1'b1; gw_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        chk("R10", {28'd0, wr_lanes}, 32'd0);
        chk("R10", {31'd0, rd_drive}, 32'd0);
        chk("R10", rdata, 32'd0);
        @(negedge clk);
        rst_n = 1'b1; gw_n = 1'b1;

        // Sweep every combination of the write controls and lane selects.
        for (int i = 0; i < 128; i++) begin
            logic [6:0] v;
            string t;
            v = 7'(i);
            t = !v[6] ? "R1" : (v[5] ? "R3" : (!v[4] ? "R4" : "R2"));
            step(v[6], v[5], v[4], v[3:0], v[3:0] ^ v[6:3],
                 32'hC3A50000 ^ (i * 32'h01030507), 1'b0, v[1], v[0] | v[2], t, "R5");
        end

        // Read back every word with no write (R7, R5).
        for (int a = 0; a < 16; a++)
            step(1'b1, 1'b1, 1'b1, 4'h0, 4'(a), 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, "R3", "R7");

        // R6: write then read the same address on the next edge.
        step(1'b0, 1'b1, 1'b1, 4'hF, 4'd3, 32'h1234_5678, 1'b0, 1'b0, 1'b1, "R1", "R6");
        step(1'b1, 1'b1, 1'b1, 4'hF, 4'd3, 32'h0, 1'b0, 1'b0, 1'b1, "R3", "R6");
        chk("R6", rdata, 32'h1234_5678);

        // R5: single lane 2 write keeps other lanes.
        step(1'b1, 1'b0, 1'b1, 4'b1011, 4'd3, 32'hAABB_CCDD, 1'b0, 1'b0, 1'b1, "R2", "R5");
        step(1'b1, 1'b1, 1'b1, 4'hF, 4'd3, 32'h0, 1'b0, 1'b0, 1'b1, "R3", "R5");
        chk("R5", rdata, 32'h12BB_5678);

        // R9: sleep holds a pending write and ignores new controls.
        step(1'b0, 1'b1, 1'b1, 4'hF, 4'd5, 32'hDEAD_BEEF, 1'b0, 1'b0, 1'b1, "R1", "R9");
        step(1'b1, 1'b0, 1'b1, 4'h0, 4'd6, 32'h0, 1'b1, 1'b0, 1'b1, "R9", "R9");
        chk("R9", {28'd0, wr_lanes}, 32'hF);
        step(1'b0, 1'b1, 1'b1, 4'hF, 4'd7, 32'h5555_5555, 1'b1, 1'b0, 1'b1, "R9", "R9");
        step(1'b1, 1'b1, 1'b1, 4'hF, 4'd5, 32'h0, 1'b0, 1'b0, 1'b1, "R9", "R9");
        chk("R9", rdata, 32'hDEAD_BEEF);
        step(1'b1, 1'b1, 1'b1, 4'hF, 4'd7, 32'h0, 1'b0, 1'b0, 1'b1, "R9", "R9");

        // R8: oe_n acts without a clock edge.
        @(negedge clk);
        oe_n = 1'b1; #1;
        chk("R8", {31'd0, rd_drive}, 32'd0);
        oe_n = 1'b0; #1;
        chk("R8", {31'd0, rd_drive}, 32'd1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule